// File: doc/BRIEF.md
# Stop Mode Sequencer

This block decides when a microcontroller may shut down its system clocks and how it wakes again. The CPU sends a one-cycle stop request. The sequencer checks that the CPU has not disabled stopping. It then waits until the coprocessor and the nonvolatile-memory controller are idle. After that it parks the chip in one of two stop flavours. Full stop turns the oscillator off as well. Pseudo stop keeps the oscillator running, which allows a faster return.

Interrupt requests are sorted into two groups: those the CPU services and those routed to the coprocessor. A CPU-serviced wake returns the chip to run mode. If the wake is from full stop, either the oscillator startup is awaited first or, with fast wake, the chip resumes at once on the internal PLL clock. A coprocessor-routed wake gives the chip clocks only for as long as the coprocessor works. Afterwards the sequencer drops back into stop by itself, unless the coprocessor flagged the CPU or its fake-activity flag was seen.

In each stop flavour, wake-source enables tell the periodic self-wake timer, ADC, real-time interrupt and watchdog groups whether they may keep working.

Top module: `stop_seq_top`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces run mode from any state: sys_clk_en=1, osc_en=1, in_full_stop=0, in_pseudo_stop=0, pll_fast_sel=0 and all wk_* outputs 0. Any pending deferral or re-entry is forgotten.
- R2: A stop_req sampled while stop_dis=1 is ignored, and the block stays in run mode.
- R3: A stop_req sampled with stop_dis=0 while cop_busy, cop_fake and nvm_busy are all 0 puts the block into stop at that clock edge. It enters pseudo stop (in_pseudo_stop=1) when pseudo_sel=1 and full stop (in_full_stop=1) when pseudo_sel=0. The two indications are never 1 together.
- R4: If cop_busy, cop_fake or nvm_busy is 1 when the stop request is accepted, sys_clk_en stays 1 while any of them is 1. Stop is entered at the first edge that samples all three at 0.
- R5: A CPU-serviced wake sampled during that deferral cancels the stop, and the block stays in run mode after the activity ends.
- R6: In full stop, sys_clk_en=0 and osc_en=0. wk_api_en and wk_adc_en follow cfg_api_en and cfg_adc_en, and wk_rti_en and wk_wdog_en are 0.
- R7: In pseudo stop, sys_clk_en=0 and osc_en=1, and all four wk_* outputs follow their cfg_* inputs.
- R8: A CPU-serviced wake is any of the following: nmi_req, ext_irq, or a line i with irq_req[i]=1, irq_mask[i]=0 and irq_to_cop[i]=0. It takes pseudo stop to run mode at the next edge. A line with irq_mask[i]=1 wakes nothing.
- R9: A wake from full stop with fast_wake_en=0 holds sys_clk_en=0 and osc_en=1. The hold ends at the first edge that samples osc_ready=1, or after startup_limit+1 cycles, whichever comes first.
- R10: A wake from full stop with fast_wake_en=1 gives sys_clk_en=1 at the next edge with pll_fast_sel=1. pll_fast_sel stays 1 until osc_ready is sampled 1.
- R11: A coprocessor-routed wake (irq_req[i]=1, irq_mask[i]=0, irq_to_cop[i]=1) gives sys_clk_en=1 until cop_busy and cop_fake are both 0. The block then re-enters the stop flavour chosen by pseudo_sel.
- R12: If cpu_flag_set or cop_fake is sampled 1 during such a coprocessor service, the block returns to run mode instead of re-entering stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_req | input | 1 | One-cycle stop request from the CPU |
| stop_dis | input | 1 | CPU stop-disable flag |
| cop_busy | input | 1 | Coprocessor is running a thread |
| cop_fake | input | 1 | Coprocessor fake-activity flag |
| cpu_flag_set | input | 1 | Coprocessor raised a CPU interrupt flag |
| nvm_busy | input | 1 | NVM command in progress |
| pseudo_sel | input | 1 | 1 selects pseudo stop, 0 full stop |
| fast_wake_en | input | 1 | Leave full stop directly on the PLL clock |
| nmi_req | input | 1 | Non-maskable interrupt |
| ext_irq | input | 1 | External interrupt pin request |
| irq_req | input | N_IRQ | Peripheral interrupt requests |
| irq_mask | input | N_IRQ | 1 masks the line |
| irq_to_cop | input | N_IRQ | 1 routes the line to the coprocessor |
| osc_ready | input | 1 | Oscillator startup finished |
| startup_limit | input | CNT_W | Oscillator wait bound in cycles |
| cfg_api_en | input | 1 | Periodic self-wake timer allowed in stop |
| cfg_adc_en | input | 1 | ADC allowed in stop |
| cfg_rti_en | input | 1 | Real-time interrupt allowed in pseudo stop |
| cfg_wdog_en | input | 1 | Watchdog allowed in pseudo stop |
| sys_clk_en | output | 1 | System clock enable |
| osc_en | output | 1 | Oscillator enable |
| in_full_stop | output | 1 | Block is in full stop |
| in_pseudo_stop | output | 1 | Block is in pseudo stop |
| wk_api_en | output | 1 | Self-wake timer enable |
| wk_adc_en | output | 1 | ADC wake enable |
| wk_rti_en | output | 1 | Real-time interrupt enable |
| wk_wdog_en | output | 1 | Watchdog enable |
| pll_fast_sel | output | 1 | System runs on PLL clock after fast wake |

## Verification
The assertions assume that startup_limit does not change while an oscillator wait is in progress. They also assume that stop_req, the busy flags and the interrupt inputs are plain synchronous levels. The random stimulus holds startup_limit fixed for the whole run and changes all other inputs only between clock edges. It keeps stop requests and wake events sparse, so the block spends long stretches in stop, deferral and coprocessor service. Busy and fake-activity flags toggle at rates that both extend and end a deferral.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;
   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_DEFER  = 3'd1,
      ST_FULL   = 3'd2,
      ST_PSEUDO = 3'd3,
      ST_OSCW   = 3'd4,
      ST_COPSVC = 3'd5
   } seq_state_t;
endpackage

// File: rtl/stop_wake_class.sv
module stop_wake_class #(
   parameter int N_IRQ = 4
) (
   input  logic             nmi_req,
   input  logic             ext_irq,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_mask,
   input  logic [N_IRQ-1:0] irq_to_cop,
   output logic             cpu_wake,
   output logic             cop_wake
);
   logic [N_IRQ-1:0] cpu_hit;
   logic [N_IRQ-1:0] cop_hit;

   generate
      if (N_IRQ < 1) begin : g_bad_n
         $error("stop_wake_class: N_IRQ must be at least 1");
      end
      for (genvar i = 0; i < N_IRQ; i++) begin : g_line
         assign cpu_hit[i] = irq_req[i] & ~irq_mask[i] & ~irq_to_cop[i];
         assign cop_hit[i] = irq_req[i] & ~irq_mask[i] &  irq_to_cop[i];
      end
   endgenerate

   assign cpu_wake = nmi_req | ext_irq | (|cpu_hit);
   assign cop_wake = |cop_hit;
endmodule

// File: rtl/stop_osc_timer.sv
module stop_osc_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] limit,
   input  logic             osc_ready,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_w
         $error("stop_osc_timer: CNT_W out of range");
      end
   endgenerate

   assign done = run_en & (osc_ready | (cnt_q >= limit));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (run_en && !done) cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= '0;
   end

   p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> (cnt_q <= limit));
   p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (cnt_q == '0));
endmodule

// File: rtl/stop_seq_fsm.sv
module stop_seq_fsm
   import stop_seq_pkg::*;
#(
   parameter bit FAST_WAKE_SUPPORT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stop_req,
   input  logic       stop_dis,
   input  logic       cop_busy,
   input  logic       cop_fake,
   input  logic       cpu_flag_set,
   input  logic       nvm_busy,
   input  logic       pseudo_sel,
   input  logic       fast_wake_en,
   input  logic       cpu_wake,
   input  logic       cop_wake,
   input  logic       osc_ready,
   input  logic       osc_done,
   output seq_state_t state,
   output logic       fast_sel
);
   seq_state_t state_q, nxt;
   logic       tgt_cop_q, tgt_cop_n;
   logic       svc_blk_q;
   logic       fast_q;
   logic       fast_set;
   logic       fast_ok;
   logic       cop_act;
   seq_state_t stop_tgt;

   generate
      if (FAST_WAKE_SUPPORT) begin : g_fast
         assign fast_ok = fast_wake_en;
      end else begin : g_nofast
         assign fast_ok = 1'b0;
      end
   endgenerate

   assign cop_act  = cop_busy | cop_fake;
   assign stop_tgt = pseudo_sel ? ST_PSEUDO : ST_FULL;

   always_comb begin
      nxt       = state_q;
      tgt_cop_n = tgt_cop_q;
      fast_set  = 1'b0;
      case (state_q)
         ST_RUN: begin
            if (stop_req && !stop_dis)
               nxt = (cop_act || nvm_busy) ? ST_DEFER : stop_tgt;
         end
         ST_DEFER: begin
            if (cpu_wake)                  nxt = ST_RUN;
            else if (!cop_act && !nvm_busy) nxt = stop_tgt;
         end
         ST_PSEUDO: begin
            if (cpu_wake)      nxt = ST_RUN;
            else if (cop_wake) nxt = ST_COPSVC;
         end
         ST_FULL: begin
            if (cpu_wake || cop_wake) begin
               if (fast_ok) begin
                  nxt      = cpu_wake ? ST_RUN : ST_COPSVC;
                  fast_set = 1'b1;
               end else begin
                  nxt       = ST_OSCW;
                  tgt_cop_n = !cpu_wake;
               end
            end
         end
         ST_OSCW: begin
            if (cpu_wake) tgt_cop_n = 1'b0;
            if (osc_done) nxt = (tgt_cop_q && !cpu_wake) ? ST_COPSVC : ST_RUN;
         end
         ST_COPSVC: begin
            if (cpu_wake) nxt = ST_RUN;
            else if (!cop_act) begin
               if (svc_blk_q || cpu_flag_set) nxt = ST_RUN;
               else if (nvm_busy)             nxt = ST_DEFER;
               else                           nxt = stop_tgt;
            end
         end
         default: nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_RUN;
         tgt_cop_q <= 1'b0;
         svc_blk_q <= 1'b0;
         fast_q    <= 1'b0;
      end else begin
         state_q   <= nxt;
         tgt_cop_q <= tgt_cop_n;
         if (nxt == ST_COPSVC && state_q != ST_COPSVC)
            svc_blk_q <= 1'b0;
         else if (state_q == ST_COPSVC && (cpu_flag_set || cop_fake))
            svc_blk_q <= 1'b1;
         if (fast_set)
            fast_q <= 1'b1;
         else if (osc_ready || nxt == ST_FULL || nxt == ST_PSEUDO)
            fast_q <= 1'b0;
      end
   end

   assign state    = state_q;
   assign fast_sel = fast_q;

   p_dis_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && stop_dis) |=> (state_q == ST_RUN));
   p_defer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEFER && !cpu_wake && (cop_busy || cop_fake || nvm_busy))
      |=> (state_q == ST_DEFER));
   p_defer_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEFER && cpu_wake) |=> (state_q == ST_RUN));
   p_pseudo_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PSEUDO && cpu_wake) |=> (state_q == ST_RUN));
   p_fast_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fast_q) |-> ($past(state_q) == ST_FULL));
   p_blocked_svc_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_COPSVC && svc_blk_q && !cop_busy && !cop_fake)
      |=> (state_q == ST_RUN));
endmodule

// File: rtl/stop_seq_top.sv
module stop_seq_top
   import stop_seq_pkg::*;
#(
   parameter int N_IRQ             = 4,
   parameter int CNT_W             = 8,
   parameter bit FAST_WAKE_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop_req,
   input  logic             stop_dis,
   input  logic             cop_busy,
   input  logic             cop_fake,
   input  logic             cpu_flag_set,
   input  logic             nvm_busy,
   input  logic             pseudo_sel,
   input  logic             fast_wake_en,
   input  logic             nmi_req,
   input  logic             ext_irq,
   input  logic [N_IRQ-1:0] irq_req,
   input  logic [N_IRQ-1:0] irq_mask,
   input  logic [N_IRQ-1:0] irq_to_cop,
   input  logic             osc_ready,
   input  logic [CNT_W-1:0] startup_limit,
   input  logic             cfg_api_en,
   input  logic             cfg_adc_en,
   input  logic             cfg_rti_en,
   input  logic             cfg_wdog_en,
   output logic             sys_clk_en,
   output logic             osc_en,
   output logic             in_full_stop,
   output logic             in_pseudo_stop,
   output logic             wk_api_en,
   output logic             wk_adc_en,
   output logic             wk_rti_en,
   output logic             wk_wdog_en,
   output logic             pll_fast_sel
);
   logic       cpu_wake, cop_wake, osc_done;
   seq_state_t st;
   logic       any_stop;

   stop_wake_class #(.N_IRQ(N_IRQ)) u_class (
      .nmi_req    (nmi_req),
      .ext_irq    (ext_irq),
      .irq_req    (irq_req),
      .irq_mask   (irq_mask),
      .irq_to_cop (irq_to_cop),
      .cpu_wake   (cpu_wake),
      .cop_wake   (cop_wake)
   );

   stop_osc_timer #(.CNT_W(CNT_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_en    (st == ST_OSCW),
      .limit     (startup_limit),
      .osc_ready (osc_ready),
      .done      (osc_done)
   );

   stop_seq_fsm #(.FAST_WAKE_SUPPORT(FAST_WAKE_SUPPORT)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_req     (stop_req),
      .stop_dis     (stop_dis),
      .cop_busy     (cop_busy),
      .cop_fake     (cop_fake),
      .cpu_flag_set (cpu_flag_set),
      .nvm_busy     (nvm_busy),
      .pseudo_sel   (pseudo_sel),
      .fast_wake_en (fast_wake_en),
      .cpu_wake     (cpu_wake),
      .cop_wake     (cop_wake),
      .osc_ready    (osc_ready),
      .osc_done     (osc_done),
      .state        (st),
      .fast_sel     (pll_fast_sel)
   );

   assign in_full_stop   = (st == ST_FULL);
   assign in_pseudo_stop = (st == ST_PSEUDO);
   assign any_stop       = in_full_stop | in_pseudo_stop;
   assign sys_clk_en     = (st == ST_RUN) | (st == ST_DEFER) | (st == ST_COPSVC);
   assign osc_en         = !in_full_stop;
   assign wk_api_en      = any_stop & cfg_api_en;
   assign wk_adc_en      = any_stop & cfg_adc_en;
   assign wk_rti_en      = in_pseudo_stop & cfg_rti_en;
   assign wk_wdog_en     = in_pseudo_stop & cfg_wdog_en;

   p_stop_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_full_stop && in_pseudo_stop));
   p_full_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_full_stop |-> (!osc_en && !sys_clk_en && !wk_rti_en && !wk_wdog_en));
   p_oscwait_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_full_stop && cpu_wake && !fast_wake_en) |=> (!sys_clk_en && osc_en));
endmodule

// File: tb/sim_stop_seq_top.sv
module sim_stop_seq_top;
   localparam int N = 4;
   localparam int CW = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, stop_req, stop_dis, cop_busy, cop_fake, cpu_flag_set, nvm_busy;
   logic pseudo_sel, fast_wake_en, nmi_req, ext_irq, osc_ready;
   logic [N-1:0] irq_req, irq_mask, irq_to_cop;
   logic [CW-1:0] startup_limit;
   logic cfg_api_en, cfg_adc_en, cfg_rti_en, cfg_wdog_en;
   logic sys_clk_en, osc_en, in_full_stop, in_pseudo_stop;
   logic wk_api_en, wk_adc_en, wk_rti_en, wk_wdog_en, pll_fast_sel;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   stop_seq_top #(.N_IRQ(N), .CNT_W(CW)) u0 (.*);

   // reference model state: 0 run,1 defer,2 full,3 pseudo,4 osc wait,5 cop service
   int ms, mcnt;
   bit mtgt, mblk, mfast;

   task automatic chk(string tag, logic act, logic exp, string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      stop_req = 0; stop_dis = 0; cop_busy = 0; cop_fake = 0; cpu_flag_set = 0;
      nvm_busy = 0; pseudo_sel = 0; fast_wake_en = 0; nmi_req = 0; ext_irq = 0;
      osc_ready = 0; irq_req = '0; irq_mask = '0; irq_to_cop = '0;
   endtask

   task automatic do_reset();
      rst_n = 0;
      tick();
      rst_n = 1;
      tick();
   endtask

   task automatic req_stop();
      stop_req = 1; tick(); stop_req = 0;
   endtask

   function automatic bit m_cpu_wake();
      return nmi_req | ext_irq | (|(irq_req & ~irq_mask & ~irq_to_cop));
   endfunction

   function automatic bit m_cop_wake();
      return |(irq_req & ~irq_mask & irq_to_cop);
   endfunction

   task automatic model_step();
      bit cw, pw, act, setf, done;
      int ns, tgt;
      cw = m_cpu_wake(); pw = m_cop_wake();
      act = cop_busy | cop_fake;
      tgt = pseudo_sel ? 3 : 2;
      ns = ms; setf = 0;
      done = (ms == 4) && (osc_ready || mcnt >= int'(startup_limit));
      case (ms)
         0: if (stop_req && !stop_dis) ns = (act || nvm_busy) ? 1 : tgt;
         1: if (cw) ns = 0; else if (!act && !nvm_busy) ns = tgt;
         3: if (cw) ns = 0; else if (pw) ns = 5;
         2: if (cw || pw) begin
               if (fast_wake_en) begin ns = cw ? 0 : 5; setf = 1; end
               else begin ns = 4; mtgt = !cw; end
            end
         4: begin
               if (done) ns = (mtgt && !cw) ? 5 : 0;
               if (cw) mtgt = 0;
            end
         5: if (cw) ns = 0;
            else if (!act) ns = (mblk || cpu_flag_set) ? 0 : (nvm_busy ? 1 : tgt);
         default: ns = 0;
      endcase
      mcnt = (ms == 4 && !done) ? mcnt + 1 : 0;
      if (ns == 5 && ms != 5) mblk = 0;
      else if (ms == 5 && (cpu_flag_set || cop_fake)) mblk = 1;
      if (setf) mfast = 1;
      else if (osc_ready || ns == 2 || ns == 3) mfast = 0;
      ms = ns;
   endtask

   task automatic model_compare();
      string tag;
      tag = (ms == 2) ? "R6" : (ms == 3) ? "R7" : (ms == 4) ? "R9" :
            (ms == 1) ? "R4" : (ms == 5) ? "R11" : "R3";
      chk(tag, sys_clk_en, ms == 0 || ms == 1 || ms == 5, "sys_clk_en");
      chk(tag, osc_en, ms != 2, "osc_en");
      chk(tag, in_full_stop, ms == 2, "in_full_stop");
      chk(tag, in_pseudo_stop, ms == 3, "in_pseudo_stop");
      chk(tag, wk_api_en, (ms == 2 || ms == 3) && cfg_api_en, "wk_api_en");
      chk(tag, wk_adc_en, (ms == 2 || ms == 3) && cfg_adc_en, "wk_adc_en");
      chk(tag, wk_rti_en, ms == 3 && cfg_rti_en, "wk_rti_en");
      chk(tag, wk_wdog_en, ms == 3 && cfg_wdog_en, "wk_wdog_en");
      chk("R10", pll_fast_sel, mfast, "pll_fast_sel");
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      int seed;
      int unused;
      idle_inputs();
      startup_limit = 8'd3;
      cfg_api_en = 1; cfg_adc_en = 0; cfg_rti_en = 1; cfg_wdog_en = 0;
      rst_n = 0;
      tick(); tick();
      // R1: reset state
      chk("R1", sys_clk_en, 1, "sys_clk_en"); chk("R1", osc_en, 1, "osc_en");
      chk("R1", in_full_stop, 0, "full"); chk("R1", pll_fast_sel, 0, "fast");
      rst_n = 1; tick();

      // R2: disabled stop ignored
      stop_dis = 1; req_stop(); tick(); stop_dis = 0;
      chk("R2", sys_clk_en, 1, "sys_clk_en"); chk("R2", in_full_stop, 0, "full");

      // R3 / R6: full stop entry and outputs
      pseudo_sel = 0; stop_req = 1; tick(); stop_req = 0;
      chk("R3", in_full_stop, 1, "full"); chk("R3", in_pseudo_stop, 0, "pseudo");
      chk("R6", osc_en, 0, "osc_en"); chk("R6", sys_clk_en, 0, "sys_clk_en");
      chk("R6", wk_api_en, 1, "wk_api_en"); chk("R6", wk_rti_en, 0, "wk_rti_en");

      // R9: timed oscillator wait, limit 3 -> 4 cycles gated
      ext_irq = 1; tick(); ext_irq = 0;
      for (int k = 0; k < 4; k++) begin
         chk("R9", sys_clk_en, 0, "sys_clk_en in wait");
         chk("R9", osc_en, 1, "osc_en in wait");
         tick();
      end
      chk("R9", sys_clk_en, 1, "sys_clk_en after wait");

      // R9: early osc_ready ends the wait
      startup_limit = 8'd50;
      req_stop(); irq_req = 4'b0001; tick(); irq_req = '0;
      chk("R9", sys_clk_en, 0, "wait start");
      osc_ready = 1; tick(); osc_ready = 0;
      chk("R9", sys_clk_en, 1, "ready ends wait");
      startup_limit = 8'd3;

      // R7 / R8: pseudo stop, masked line ignored, nmi wakes
      pseudo_sel = 1; stop_req = 1; tick(); stop_req = 0;
      chk("R7", in_pseudo_stop, 1, "pseudo"); chk("R7", osc_en, 1, "osc_en");
      chk("R7", sys_clk_en, 0, "sys_clk_en"); chk("R7", wk_rti_en, 1, "wk_rti_en");
      irq_mask = 4'b0010; irq_req = 4'b0010; tick(); irq_req = '0; irq_mask = '0;
      chk("R8", in_pseudo_stop, 1, "masked line ignored");
      nmi_req = 1; tick(); nmi_req = 0;
      chk("R8", sys_clk_en, 1, "nmi wake"); chk("R8", in_pseudo_stop, 0, "pseudo left");

      // R4: deferral while busy
      pseudo_sel = 0; cop_busy = 1; req_stop();
      chk("R4", sys_clk_en, 1, "clk during defer");
      nvm_busy = 1; cop_busy = 0; tick();
      chk("R4", sys_clk_en, 1, "clk nvm busy");
      nvm_busy = 0; tick();
      chk("R4", in_full_stop, 1, "stop after idle");
      ext_irq = 1; tick(); ext_irq = 0; osc_ready = 1; tick(); osc_ready = 0;
      chk("R4", sys_clk_en, 1, "back to run");

      // R5: cancel during deferral
      nvm_busy = 1; req_stop();
      irq_req = 4'b0100; tick(); irq_req = '0;
      nvm_busy = 0; tick(); tick();
      chk("R5", in_full_stop, 0, "cancelled"); chk("R5", sys_clk_en, 1, "run");

      // R10: fast wake from full stop
      fast_wake_en = 1; req_stop();
      chk("R10", in_full_stop, 1, "full");
      ext_irq = 1; tick(); ext_irq = 0;
      chk("R10", sys_clk_en, 1, "immediate clk"); chk("R10", pll_fast_sel, 1, "fast sel");
      tick(); chk("R10", pll_fast_sel, 1, "fast sel held");
      osc_ready = 1; tick(); osc_ready = 0;
      chk("R10", pll_fast_sel, 0, "fast sel cleared");
      fast_wake_en = 0;

      // R11: coprocessor-routed wake re-enters pseudo stop
      pseudo_sel = 1; req_stop();
      irq_to_cop = 4'b1000; irq_req = 4'b1000; tick(); irq_req = '0;
      chk("R11", sys_clk_en, 1, "service clk"); chk("R11", in_pseudo_stop, 0, "left");
      cop_busy = 1; tick(); tick();
      chk("R11", sys_clk_en, 1, "busy keeps clk");
      cop_busy = 0; tick();
      chk("R11", in_pseudo_stop, 1, "re-entered");

      // R12: cpu flag during service returns to run
      irq_req = 4'b1000; tick(); irq_req = '0;
      cop_busy = 1; cpu_flag_set = 1; tick(); cpu_flag_set = 0;
      cop_busy = 0; tick(); tick();
      chk("R12", in_pseudo_stop, 0, "no re-entry"); chk("R12", sys_clk_en, 1, "run");
      irq_to_cop = '0;

      // R1: reset from pseudo stop
      req_stop();
      chk("R1", in_pseudo_stop, 1, "pre-reset pseudo");
      #3 rst_n = 0; #2;
      chk("R1", sys_clk_en, 1, "reset forces run");
      chk("R1", in_pseudo_stop, 0, "reset clears pseudo");
      tick(); rst_n = 1; tick();

      // random phase with reference model
      idle_inputs();
      startup_limit = 8'd5;
      seed = 1234;
      unused = $urandom(seed);
      do_reset();
      ms = 0; mcnt = 0; mtgt = 0; mblk = 0; mfast = 0;
      for (int c = 0; c < 4000; c++) begin
         model_compare();
         stop_req     = ($urandom % 6) == 0;
         stop_dis     = ($urandom % 4) == 0;
         cop_busy     = ($urandom % 4) == 0;
         cop_fake     = ($urandom % 30) == 0;
         cpu_flag_set = ($urandom % 20) == 0;
         nvm_busy     = ($urandom % 5) == 0;
         pseudo_sel   = $urandom % 2;
         fast_wake_en = $urandom % 2;
         nmi_req      = ($urandom % 100) == 0;
         ext_irq      = ($urandom % 60) == 0;
         osc_ready    = ($urandom % 6) == 0;
         irq_mask     = N'($urandom);
         irq_to_cop   = N'($urandom);
         for (int b = 0; b < N; b++) irq_req[b] = ($urandom % 25) == 0;
         cfg_api_en = $urandom % 2; cfg_adc_en = $urandom % 2;
         cfg_rti_en = $urandom % 2; cfg_wdog_en = $urandom % 2;
         model_step();
         tick();
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule